// File: doc/BRIEF.md
# Programmable Active-Matrix Panel Timing Generator

This block produces every timing signal an active-matrix LCD panel needs: a pixel clock, a horizontal sync, a vertical sync and a data-enable strobe. It also gives an upstream pixel source a fetch strobe and the x/y coordinates of each visible pixel. It runs from one internal clock at twice the pixel rate. The pixel clock is that clock divided by two, and every output is a register clocked on one of the two internal-clock phases. Because of this, the choice of which pixel-clock edge moves the sync lines needs no second clock domain.

The raster geometry comes from static configuration inputs: visible width and height, horizontal and vertical sync widths, and back and front porches. The fields do not share one encoding. Width, height, horizontal porches and both sync widths mean value plus one. The vertical porches are taken as written, so zero is legal. The geometry is captured at the first pixel of each frame, so a frame never mixes old and new timing. Four invert bits set the active level of the pixel clock, DE, HSYNC and VSYNC. Two more bits choose the pixel-clock edge on which the sync lines change.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held, and for two internal clocks after the asynchronous active-low reset is released, pclk_o equals the pixel-clock invert bit, and DE, HSYNC and VSYNC sit at their inactive levels (the matching invert bit). pix_fetch_o, pix_x_o and pix_y_o are 0. The first pixel after reset is pixel 0 of line 0, the first vertical sync line.
- R2: pclk_o toggles on every internal clock. Pixel data, DE and the fetch strobe are launched on the internal edge that makes the un-inverted pixel clock rise, so with the pixel-clock invert bit set they leave on the falling edge of pclk_o.
- R3: Each line is, in order, hsync for cfg_hsync_w_i+1 pixels, back porch for cfg_hback_i+1, active for cfg_line_px_i+1, and front porch for cfg_hfront_i+1.
- R4: Each frame is, in order, vsync for cfg_vsync_w_i+1 lines, back porch for cfg_vback_i lines, active for cfg_frame_ln_i+1 lines, and front porch for cfg_vfront_i lines. A porch value of 0 removes that porch.
- R5: DE is active only for pixels that lie both in the active span of the line and in an active line.
- R6: pix_fetch_o is high for the one internal clock after each active pixel is launched and low otherwise. pix_x_o and pix_y_o give that pixel's column and row counted from 0 at the top-left of the active area, and they hold their value between active pixels.
- R7: cfg_inv_de_i, cfg_inv_hs_i and cfg_inv_vs_i each make their output active low when set and active high when clear.
- R8: With cfg_sync_edge_en_i clear, HSYNC and VSYNC change on the pixel-clock edge opposite the data launch edge, half a pixel after DE.
- R9: With cfg_sync_edge_en_i set, HSYNC and VSYNC change on the rising edge of pclk_o when cfg_sync_edge_rise_i is 1 and on its falling edge when it is 0. On the data edge they change together with DE, and on the other edge half a pixel later.
- R10: Geometry inputs changed in the middle of a frame take effect only at the first pixel of the next frame.
- R11: With every geometry field 0, a line is 4 pixels (one of each part) and a frame is 2 lines (one sync line, one active line).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Internal clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_line_px_i | input | 12 | Visible pixels per line minus one |
| cfg_frame_ln_i | input | 12 | Visible lines per frame minus one |
| cfg_hback_i | input | 12 | Horizontal back porch minus one |
| cfg_hfront_i | input | 12 | Horizontal front porch minus one |
| cfg_hsync_w_i | input | 8 | Horizontal sync width minus one |
| cfg_vback_i | input | 12 | Vertical back porch in lines |
| cfg_vfront_i | input | 12 | Vertical front porch in lines |
| cfg_vsync_w_i | input | 8 | Vertical sync width minus one, in lines |
| cfg_sync_edge_en_i | input | 1 | Enables explicit choice of the sync launch edge |
| cfg_sync_edge_rise_i | input | 1 | Selected sync edge: 1 rising, 0 falling edge of pclk_o |
| cfg_inv_de_i | input | 1 | DE active low when set |
| cfg_inv_pclk_i | input | 1 | Inverts the pixel clock |
| cfg_inv_hs_i | input | 1 | HSYNC active low when set |
| cfg_inv_vs_i | input | 1 | VSYNC active low when set |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_fetch_o | output | 1 | One-cycle strobe per active pixel |
| pix_x_o | output | 12 | Column of the current active pixel |
| pix_y_o | output | 12 | Row of the current active pixel |

## Verification
The bench targets the zero-length vertical porches and the all-zero geometry. A design that added an offset to every field would produce frames longer than expected, and one that could not reach a zero-length porch would lock up or wrap early. It covers all four combinations of edge select and pixel-clock inversion. A wrong edge decode shows up as sync lines moving half a pixel early or late relative to DE. It also changes the geometry at random points mid-frame, where a design that samples its inputs continuously would bend the current frame instead of the next one.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  // Which part of a line (or of a frame) a position falls in.
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } tg_seg_e;

endpackage

// File: rtl/lcd_tg_clkphase.sv
// Divide-by-two phase generator and launch-edge decode.
module lcd_tg_clkphase (
  input  logic clk,
  input  logic rst_n,
  input  logic inv_pclk,
  input  logic edge_en,
  input  logic edge_rise,
  output logic ph_o,
  output logic data_edge_o,
  output logic sync_on_data_o,
  output logic pclk_o
);

  logic ph_q, ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // The edge taken with ph_q low raises the raw pixel clock: data launches there.
  // The sync lines use that same edge only when explicit edge control selects
  // the pclk_o edge that coincides with the raw rising edge.
  always_comb begin
    data_edge_o    = ~ph_q;
    sync_on_data_o = edge_en & (edge_rise ^ inv_pclk);
    pclk_o         = ph_q ^ inv_pclk;
    ph_o           = ph_q;
  end

endmodule

// File: rtl/lcd_tg_axis.sv
// One raster axis: a position counter and a four-part segment decode.
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [CNT_W-1:0] cur_sync,
  input  logic [CNT_W-1:0] cur_back,
  input  logic [CNT_W-1:0] cur_act,
  input  logic [CNT_W-1:0] cur_front,
  input  logic [CNT_W-1:0] nxt_sync,
  input  logic [CNT_W-1:0] nxt_back,
  input  logic [CNT_W-1:0] nxt_act,
  output logic             last_o,
  output tg_seg_e          seg_o,
  output logic [POS_W-1:0] pos_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] total, b_back, b_act, b_front;

  // Wrap decision uses the geometry of the frame in progress.
  always_comb begin
    total  = cur_sync + cur_back + cur_act + cur_front;
    last_o = (cnt_q == total - ONE);
    if (start)     cnt_d = '0;
    else if (en)   cnt_d = last_o ? '0 : cnt_q + ONE;
    else           cnt_d = cnt_q;
  end

  // Segment decode of the position about to be shown, with the geometry
  // that applies to it (which changes at a frame boundary).
  always_comb begin
    b_back  = nxt_sync;
    b_act   = nxt_sync + nxt_back;
    b_front = b_act + nxt_act;
    if (cnt_d < b_back)       seg_o = SEG_SYNC;
    else if (cnt_d < b_act)   seg_o = SEG_BACK;
    else if (cnt_d < b_front) seg_o = SEG_ACT;
    else                      seg_o = SEG_FRONT;
    pos_o = POS_W'(cnt_d - b_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (en | start) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lcd_tg_outstage.sv
// Launch registers for data-side and sync-side outputs.
module lcd_tg_outstage #(
  parameter int unsigned POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_edge,
  input  logic             sync_on_data,
  input  logic             de_d,
  input  logic             hs_d,
  input  logic             vs_d,
  input  logic [POS_W-1:0] x_d,
  input  logic [POS_W-1:0] y_d,
  output logic             de_q,
  output logic             fetch_q,
  output logic             hs_mid_q,
  output logic             vs_mid_q,
  output logic             hs_q,
  output logic             vs_q,
  output logic [POS_W-1:0] x_q,
  output logic [POS_W-1:0] y_q
);

  logic             de_n, fetch_n, hs_mid_n, vs_mid_n, hs_n, vs_n;
  logic [POS_W-1:0] x_n, y_n;
  logic             data_en, sync_en, xy_en;

  always_comb begin
    data_en  = data_edge;
    xy_en    = data_edge & de_d;
    // Sync launches either together with data or on the next (opposite) edge.
    sync_en  = data_edge ? sync_on_data : ~sync_on_data;
    de_n     = de_d;
    fetch_n  = data_edge & de_d;
    hs_mid_n = hs_d;
    vs_mid_n = vs_d;
    hs_n     = data_edge ? hs_d : hs_mid_q;
    vs_n     = data_edge ? vs_d : vs_mid_q;
    x_n      = x_d;
    y_n      = y_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q     <= 1'b0;
      hs_mid_q <= 1'b0;
      vs_mid_q <= 1'b0;
    end else if (data_en) begin
      de_q     <= de_n;
      hs_mid_q <= hs_mid_n;
      vs_mid_q <= vs_mid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_q <= 1'b0;
    else        fetch_q <= fetch_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else if (sync_en) begin
      hs_q <= hs_n;
      vs_q <= vs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (xy_en) begin
      x_q <= x_n;
      y_q <= y_n;
    end
  end

endmodule

// File: rtl/lcd_timing_gen.sv
// Active-matrix panel timing generator (top).
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned FLD_W  = 12,
  parameter int unsigned SYNC_W = 8
) (
  input  logic              clk2x_i,
  input  logic              rst_ni,
  input  logic [FLD_W-1:0]  cfg_line_px_i,
  input  logic [FLD_W-1:0]  cfg_frame_ln_i,
  input  logic [FLD_W-1:0]  cfg_hback_i,
  input  logic [FLD_W-1:0]  cfg_hfront_i,
  input  logic [SYNC_W-1:0] cfg_hsync_w_i,
  input  logic [FLD_W-1:0]  cfg_vback_i,
  input  logic [FLD_W-1:0]  cfg_vfront_i,
  input  logic [SYNC_W-1:0] cfg_vsync_w_i,
  input  logic              cfg_sync_edge_en_i,
  input  logic              cfg_sync_edge_rise_i,
  input  logic              cfg_inv_de_i,
  input  logic              cfg_inv_pclk_i,
  input  logic              cfg_inv_hs_i,
  input  logic              cfg_inv_vs_i,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pix_fetch_o,
  output logic [FLD_W-1:0]  pix_x_o,
  output logic [FLD_W-1:0]  pix_y_o
);

  // Four parts of up to 2^FLD_W each fit in FLD_W+2 bits.
  localparam int unsigned CNT_W = FLD_W + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] ext_f(input logic [FLD_W-1:0] v);
    return {{(CNT_W-FLD_W){1'b0}}, v};
  endfunction

  function automatic logic [CNT_W-1:0] ext_s(input logic [SYNC_W-1:0] v);
    return {{(CNT_W-SYNC_W){1'b0}}, v};
  endfunction

  // Reset: asserted asynchronously, released after two internal clocks.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Clock phase.
  logic ph, data_edge, sync_on_data;

  lcd_tg_clkphase u_phase (
    .clk            (clk2x_i),
    .rst_n          (rst_n_int),
    .inv_pclk       (cfg_inv_pclk_i),
    .edge_en        (cfg_sync_edge_en_i),
    .edge_rise      (cfg_sync_edge_rise_i),
    .ph_o           (ph),
    .data_edge_o    (data_edge),
    .sync_on_data_o (sync_on_data),
    .pclk_o         (pclk_o)
  );

  // Shadow copy of the geometry of the frame in progress.
  logic [FLD_W-1:0]  sh_line_px, sh_frame_ln, sh_hback, sh_hfront, sh_vback, sh_vfront;
  logic [SYNC_W-1:0] sh_hsync_w, sh_vsync_w;

  logic run_q, run_d;
  logic h_en, h_start, v_en, h_last, v_last, frame_start;

  logic [CNT_W-1:0] cur_hs, cur_hb, cur_ha, cur_hf, cur_vs, cur_vb, cur_va, cur_vf;
  logic [CNT_W-1:0] liv_hs, liv_hb, liv_ha, liv_vs, liv_vb, liv_va;
  logic [CNT_W-1:0] nxt_hs, nxt_hb, nxt_ha, nxt_vs, nxt_vb, nxt_va;

  always_comb begin
    h_start     = data_edge & ~run_q;
    h_en        = data_edge & run_q;
    v_en        = h_en & h_last;
    frame_start = h_start | (v_en & v_last);
    run_d       = 1'b1;
  end

  // Encodings: horizontal parts, sync widths and the active size are value
  // plus one; the vertical porches are used as written.
  always_comb begin
    cur_hs = ext_s(sh_hsync_w) + ONE;
    cur_hb = ext_f(sh_hback)   + ONE;
    cur_ha = ext_f(sh_line_px) + ONE;
    cur_hf = ext_f(sh_hfront)  + ONE;
    cur_vs = ext_s(sh_vsync_w) + ONE;
    cur_vb = ext_f(sh_vback);
    cur_va = ext_f(sh_frame_ln) + ONE;
    cur_vf = ext_f(sh_vfront);

    liv_hs = ext_s(cfg_hsync_w_i) + ONE;
    liv_hb = ext_f(cfg_hback_i)   + ONE;
    liv_ha = ext_f(cfg_line_px_i) + ONE;
    liv_vs = ext_s(cfg_vsync_w_i) + ONE;
    liv_vb = ext_f(cfg_vback_i);
    liv_va = ext_f(cfg_frame_ln_i) + ONE;

    nxt_hs = frame_start ? liv_hs : cur_hs;
    nxt_hb = frame_start ? liv_hb : cur_hb;
    nxt_ha = frame_start ? liv_ha : cur_ha;
    nxt_vs = frame_start ? liv_vs : cur_vs;
    nxt_vb = frame_start ? liv_vb : cur_vb;
    nxt_va = frame_start ? liv_va : cur_va;
  end

  always_ff @(posedge clk2x_i or negedge rst_n_int) begin
    if (!rst_n_int)   run_q <= 1'b0;
    else if (h_start) run_q <= run_d;
  end

  always_ff @(posedge clk2x_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      sh_line_px  <= '0;
      sh_frame_ln <= '0;
      sh_hback    <= '0;
      sh_hfront   <= '0;
      sh_hsync_w  <= '0;
      sh_vback    <= '0;
      sh_vfront   <= '0;
      sh_vsync_w  <= '0;
    end else if (frame_start) begin
      sh_line_px  <= cfg_line_px_i;
      sh_frame_ln <= cfg_frame_ln_i;
      sh_hback    <= cfg_hback_i;
      sh_hfront   <= cfg_hfront_i;
      sh_hsync_w  <= cfg_hsync_w_i;
      sh_vback    <= cfg_vback_i;
      sh_vfront   <= cfg_vfront_i;
      sh_vsync_w  <= cfg_vsync_w_i;
    end
  end

  // Horizontal and vertical axes.
  tg_seg_e          h_seg, v_seg;
  logic [FLD_W-1:0] h_pos, v_pos;

  lcd_tg_axis #(.CNT_W(CNT_W), .POS_W(FLD_W)) u_haxis (
    .clk       (clk2x_i),
    .rst_n     (rst_n_int),
    .en        (h_en),
    .start     (h_start),
    .cur_sync  (cur_hs),
    .cur_back  (cur_hb),
    .cur_act   (cur_ha),
    .cur_front (cur_hf),
    .nxt_sync  (nxt_hs),
    .nxt_back  (nxt_hb),
    .nxt_act   (nxt_ha),
    .last_o    (h_last),
    .seg_o     (h_seg),
    .pos_o     (h_pos)
  );

  lcd_tg_axis #(.CNT_W(CNT_W), .POS_W(FLD_W)) u_vaxis (
    .clk       (clk2x_i),
    .rst_n     (rst_n_int),
    .en        (v_en),
    .start     (h_start),
    .cur_sync  (cur_vs),
    .cur_back  (cur_vb),
    .cur_act   (cur_va),
    .cur_front (cur_vf),
    .nxt_sync  (nxt_vs),
    .nxt_back  (nxt_vb),
    .nxt_act   (nxt_va),
    .last_o    (v_last),
    .seg_o     (v_seg),
    .pos_o     (v_pos)
  );

  // Output launch.
  logic de_d, hs_d, vs_d;
  logic de_raw, hs_mid, vs_mid, hs_raw, vs_raw;

  always_comb begin
    de_d = (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
    hs_d = (h_seg == SEG_SYNC);
    vs_d = (v_seg == SEG_SYNC);
  end

  lcd_tg_outstage #(.POS_W(FLD_W)) u_out (
    .clk          (clk2x_i),
    .rst_n        (rst_n_int),
    .data_edge    (data_edge),
    .sync_on_data (sync_on_data),
    .de_d         (de_d),
    .hs_d         (hs_d),
    .vs_d         (vs_d),
    .x_d          (h_pos),
    .y_d          (v_pos),
    .de_q         (de_raw),
    .fetch_q      (pix_fetch_o),
    .hs_mid_q     (hs_mid),
    .vs_mid_q     (vs_mid),
    .hs_q         (hs_raw),
    .vs_q         (vs_raw),
    .x_q          (pix_x_o),
    .y_q          (pix_y_o)
  );

  always_comb begin
    de_o    = de_raw ^ cfg_inv_de_i;
    hsync_o = hs_raw ^ cfg_inv_hs_i;
    vsync_o = vs_raw ^ cfg_inv_vs_i;
  end

endmodule

// File: rtl/lcd_tg_chk.sv
// Property checker for lcd_timing_gen, attached by bind.
module lcd_tg_chk (
  input logic clk,
  input logic rst_n,
  input logic ph,
  input logic sync_on_data,
  input logic de_raw,
  input logic hs_mid,
  input logic vs_mid,
  input logic hs_raw,
  input logic vs_raw,
  input logic fetch
);

  // R2: the phase flips on every internal clock.
  a_r2_pclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph != $past(ph)));

  // R5: no active pixel during a horizontal sync pixel.
  a_r5_de_not_in_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !hs_mid);

  // R5: no active pixel during a vertical sync line.
  a_r5_de_not_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !vs_mid);

  // R6: a fetch strobe only accompanies an active pixel.
  a_r6_fetch_needs_de: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> de_raw);

  // R8: in opposite-edge mode the sync lines hold across data edges.
  a_r8_sync_hold_on_data_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ph) && !$past(sync_on_data)) |-> ($stable(hs_raw) && $stable(vs_raw)));

  // R9: in data-edge sync mode the sync lines hold across the other edge.
  a_r9_sync_hold_off_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph) && $past(sync_on_data)) |-> ($stable(hs_raw) && $stable(vs_raw)));

endmodule

bind lcd_timing_gen lcd_tg_chk u_chk (
  .clk          (clk2x_i),
  .rst_n        (rst_n_int),
  .ph           (ph),
  .sync_on_data (sync_on_data),
  .de_raw       (de_raw),
  .hs_mid       (hs_mid),
  .vs_mid       (vs_mid),
  .hs_raw       (hs_raw),
  .vs_raw       (vs_raw),
  .fetch        (pix_fetch_o)
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] line_px, frame_ln, hback, hfront, vback, vfront;
  logic [7:0]  hsw, vsw;
  logic        e_en, e_rise, i_de, i_pclk, i_hs, i_vs;
  logic        pclk_o, hsync_o, vsync_o, de_o, fetch_o;
  logic [11:0] x_o, y_o;

  always #4 clk = ~clk;   // 125 MHz

  lcd_timing_gen u0 (
    .clk2x_i(clk), .rst_ni(rst_n),
    .cfg_line_px_i(line_px), .cfg_frame_ln_i(frame_ln),
    .cfg_hback_i(hback), .cfg_hfront_i(hfront), .cfg_hsync_w_i(hsw),
    .cfg_vback_i(vback), .cfg_vfront_i(vfront), .cfg_vsync_w_i(vsw),
    .cfg_sync_edge_en_i(e_en), .cfg_sync_edge_rise_i(e_rise),
    .cfg_inv_de_i(i_de), .cfg_inv_pclk_i(i_pclk),
    .cfg_inv_hs_i(i_hs), .cfg_inv_vs_i(i_vs),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_fetch_o(fetch_o), .pix_x_o(x_o), .pix_y_o(y_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string ctx   = "R8";

  // Reference model state.
  bit m_ph = 0, m_run = 0;
  int m_h = 0, m_v = 0;
  int s_hsw, s_hbp, s_ppl, s_hfp, s_vsw, s_vbp, s_lpp, s_vfp;
  bit e_de = 0, e_fetch = 0, e_hmid = 0, e_vmid = 0, e_hs = 0, e_vs = 0;
  int e_x = 0, e_y = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, ctx, act, exp, $time);
    end
  endtask

  // R9: sync launches with data when the chosen pclk_o edge is the raw rising one.
  function automatic bit sync_with_data();
    return e_en && (e_rise != i_pclk);
  endfunction

  task automatic latch_geom();
    s_hsw = int'(hsw); s_hbp = int'(hback); s_ppl = int'(line_px); s_hfp = int'(hfront);
    s_vsw = int'(vsw); s_vbp = int'(vback); s_lpp = int'(frame_ln); s_vfp = int'(vfront);
  endtask

  // Account for one internal rising edge.
  task automatic model_edge();
    bit hn, vn, dn;
    int h0, v0;
    if (!m_ph) begin
      if (!m_run) begin
        m_run = 1; m_h = 0; m_v = 0; latch_geom();
      end else begin
        m_h++;
        if (m_h == s_hsw + s_hbp + s_ppl + s_hfp + 4) begin
          m_h = 0; m_v++;
          if (m_v == s_vsw + 1 + s_vbp + s_lpp + 1 + s_vfp) begin
            m_v = 0; latch_geom();   // R10
          end
        end
      end
      h0 = s_hsw + 1 + s_hbp + 1;
      v0 = s_vsw + 1 + s_vbp;
      hn = (m_h < s_hsw + 1);
      vn = (m_v < s_vsw + 1);
      dn = (m_h >= h0) && (m_h < h0 + s_ppl + 1) && (m_v >= v0) && (m_v < v0 + s_lpp + 1);
      e_de = dn; e_fetch = dn;
      if (dn) begin e_x = m_h - h0; e_y = m_v - v0; end
      if (sync_with_data()) begin e_hs = hn; e_vs = vn; end
      e_hmid = hn; e_vmid = vn;
    end else begin
      e_fetch = 0;
      if (!sync_with_data()) begin e_hs = e_hmid; e_vs = e_vmid; end
    end
    m_ph = !m_ph;
  endtask

  task automatic compare();
    chk("R2 pclk",  int'(pclk_o),  int'(m_ph ^ i_pclk));
    chk("R5 de",    int'(de_o),    int'(e_de ^ i_de));
    chk("R3 hsync", int'(hsync_o), int'(e_hs ^ i_hs));
    chk("R4 vsync", int'(vsync_o), int'(e_vs ^ i_vs));
    chk("R6 fetch", int'(fetch_o), int'(e_fetch));
    chk("R6 x",     int'(x_o),     e_x);
    chk("R6 y",     int'(y_o),     e_y);
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_edge();
      compare();
    end
  endtask

  task automatic set_geom(int a, int b, int c, int d, int e, int f, int g, int h);
    hsw = 8'(a); hback = 12'(b); line_px = 12'(c); hfront = 12'(d);
    vsw = 8'(e); vback = 12'(f); frame_ln = 12'(g); vfront = 12'(h);
  endtask

  task automatic set_mode(bit en, bit rise, bit ide, bit ipc, bit ihs, bit ivs);
    e_en = en; e_rise = rise; i_de = ide; i_pclk = ipc; i_hs = ihs; i_vs = ivs;
  endtask

  function automatic int frame_cycles();
    return 2 * (int'(hsw) + int'(hback) + int'(line_px) + int'(hfront) + 4)
             * (int'(vsw) + 1 + int'(vback) + int'(frame_ln) + 1 + int'(vfront));
  endfunction

  task automatic check_reset_state();
    chk("R1 pclk",  int'(pclk_o),  int'(i_pclk));
    chk("R1 de",    int'(de_o),    int'(i_de));
    chk("R1 hsync", int'(hsync_o), int'(i_hs));
    chk("R1 vsync", int'(vsync_o), int'(i_vs));
    chk("R1 fetch", int'(fetch_o), 0);
    chk("R1 x",     int'(x_o),     0);
    chk("R1 y",     int'(y_o),     0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1ce5_7a11));
    rst_n = 1'b0;
    set_geom(1, 2, 5, 1, 1, 1, 3, 1);
    set_mode(0, 0, 1, 1, 1, 1);
    ctx = "R1";
    repeat (3) @(negedge clk);
    check_reset_state();
    set_mode(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;            // released at a falling edge
    @(negedge clk); check_reset_state();
    @(negedge clk); check_reset_state();

    // R1: first pixel is the first sync pixel: hsync and vsync both active.
    run_cycles(2);
    chk("R1 first hsync", int'(hsync_o), 1);
    chk("R1 first vsync", int'(vsync_o), 1);

    ctx = "R8";
    run_cycles(2 * frame_cycles());

    // R4 / R11: zero vertical porches, taken at next frame start.
    ctx = "R4";
    set_geom(0, 1, 3, 0, 0, 0, 2, 0);
    run_cycles(3 * 520);

    ctx = "R11";
    set_geom(0, 0, 0, 0, 0, 0, 0, 0);
    run_cycles(4 * 520);

    ctx = "R9";
    set_geom(2, 1, 4, 2, 0, 1, 2, 1);
    for (int k = 0; k < 4; k++) begin
      set_mode(1, k[0], 0, k[1], 0, 0);
      run_cycles(2 * 600);
    end

    ctx = "R7";
    for (int k = 0; k < 8; k++) begin
      set_mode(k[2], 1, k[0], k[2], k[1], !k[0]);
      run_cycles(300);
    end

    // R10: geometry changes at random points inside frames.
    ctx = "R10";
    for (int k = 0; k < 30; k++) begin
      set_geom($urandom_range(3), $urandom_range(3), $urandom_range(7), $urandom_range(3),
               $urandom_range(2), $urandom_range(2), $urandom_range(5), $urandom_range(2));
      set_mode(1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
               1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      run_cycles(200 + $urandom_range(1300));
    end

    summary();
    $finish;
  end

endmodule